// File: doc/BRIEF.md
# Power Bus Script Sequencer

This block runs short power-management scripts stored in a byte-wide script memory outside the block. A script is a chain of four-byte instruction records. Each record holds a 16-bit power-bus message, a delay and the index of the record that follows it. Four event strobes can start a script: warm reset, active-to-sleep, wake for groups one and two, and wake for group three. Each event has its own start-index input.

For each record, the block reads the four bytes one per cycle through a combinational read port. It then offers the message on a valid/ready port. After the handshake it waits the programmed number of strobes from an external timebase, then follows the next-index field. An index of all ones (0x3F with the default width) ends the script once that record's delay has elapsed.

Events that arrive while a script runs are latched and served in priority order once the block is idle. Message layout, for reference: bits 15:13 are the device-group mask (group 1 = 0x1, 2 = 0x2, 3 = 0x4) and bit 12 is broadcast (1) or singular (0). Bits 11:4 carry a resource ID, or resource group, type2 and type. Bits 3:0 carry the target state: 0x0 off, 0x8 sleep, 0xE active, 0xF warm reset. The block forwards the message unchanged.

Top module: `pbus_script_seq`

## Requirements
- R1: After reset `busy` and `msg_valid` are low and no event is pending, so no message is sent until an event strobe arrives.
- R2: Record N occupies memory bytes 4N..4N+3. Byte 4N is the message high byte, 4N+1 the low byte, 4N+2 the delay and 4N+3 the next index. The message is sent as {byte 4N, byte 4N+1}.
- R3: After a record's delay, the block fetches the record named by its next-index field. A next index of all ones (0x3F) ends the script and returns the block to idle.
- R4: A delay of D > 0 means no further fetch or message until D `tick` strobes have been seen after the message handshake.
- R5: A delay of 0 starts the next fetch in the cycle after the handshake, so the next handshake follows 5 cycles later when `msg_ready` is held high.
- R6: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and `msg_data` stays stable.
- R7: Each event starts at its own start index: `ev_warm` at `start_warm`, `ev_sleep` at `start_sleep`, `ev_wake12` at `start_wake12` and `ev_wake3` at `start_wake3`.
- R8: An event strobed while a script runs is held pending. It starts only after the running script ends and does not disturb that script.
- R9: Among pending events, the order of service is warm reset first, then active-to-sleep, then wake for groups 1 and 2, then wake for group 3.
- R10: `busy` rises two clock edges after an event strobe on an idle block, at the first fetch. It falls right after the terminating record has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sleep | input | 1 | Active-to-sleep event strobe |
| ev_wake12 | input | 1 | Wake strobe for groups 1 and 2 |
| ev_wake3 | input | 1 | Wake strobe for group 3 |
| ev_warm | input | 1 | Warm-reset event strobe |
| start_sleep | input | IDX_W | Start index of the active-to-sleep script |
| start_wake12 | input | IDX_W | Start index of the group 1/2 wake script |
| start_wake3 | input | IDX_W | Start index of the group 3 wake script |
| start_warm | input | IDX_W | Start index of the warm-reset script |
| tick | input | 1 | Timebase strobe for delays |
| mem_raddr | output | IDX_W+2 | Script memory byte address |
| mem_rdata | input | 8 | Script memory byte, same-cycle read |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts message |
| msg_data | output | 16 | Power-bus message |
| busy | output | 1 | Script in progress |

## Verification
The assertions assume that the script memory returns the addressed byte in the same cycle. They also assume that the memory contents and start indices do not change while a script runs, and that every chain ends at the terminator. The bench loads all scripts before any event and never writes memory afterwards. Every chain it builds reaches 0x3F within two records. Ticks and event strobes are single-cycle pulses driven on the falling edge, so each is sampled exactly once.

// File: rtl/pbus_script_seq.sv
module pbus_script_seq #(
  parameter int IDX_W = 6,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_sleep,
  input  logic             ev_wake12,
  input  logic             ev_wake3,
  input  logic             ev_warm,
  input  logic [IDX_W-1:0] start_sleep,
  input  logic [IDX_W-1:0] start_wake12,
  input  logic [IDX_W-1:0] start_wake3,
  input  logic [IDX_W-1:0] start_warm,
  input  logic             tick,
  output logic [IDX_W+1:0] mem_raddr,
  input  logic [7:0]       mem_rdata,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [15:0]      msg_data,
  output logic             busy
);
  localparam logic [IDX_W-1:0] TERM = '1;
  localparam logic [DLY_W-1:0] DONE_ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_WAIT} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx, nxt, first;
  logic [1:0]       bsel;
  logic [15:0]      msg;
  logic [DLY_W-1:0] dly, wcnt;
  logic [3:0]       pend, grant;
  logic             step;

  wire [3:0] ev = {ev_warm, ev_sleep, ev_wake12, ev_wake3};

  always_comb begin
    grant = 4'b0000;
    first = start_wake3;
    if (pend[3])      begin grant = 4'b1000; first = start_warm;   end
    else if (pend[2]) begin grant = 4'b0100; first = start_sleep;  end
    else if (pend[1]) begin grant = 4'b0010; first = start_wake12; end
    else if (pend[0]) begin grant = 4'b0001; first = start_wake3;  end
  end

  assign step = (st == S_SEND && msg_ready && dly == '0) ||
                (st == S_WAIT && tick && (wcnt + DONE_ONE) == dly);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      nxt  <= '0;
      bsel <= '0;
      msg  <= '0;
      dly  <= '0;
      wcnt <= '0;
      pend <= '0;
    end else begin
      pend <= (pend & ~((st == S_IDLE) ? grant : 4'b0000)) | ev;
      case (st)
        S_IDLE: if (|pend) begin
          st   <= S_FETCH;
          idx  <= first;
          bsel <= '0;
        end
        S_FETCH: begin
          bsel <= bsel + 2'd1;
          case (bsel)
            2'd0: msg[15:8] <= mem_rdata;
            2'd1: msg[7:0]  <= mem_rdata;
            2'd2: dly       <= mem_rdata[DLY_W-1:0];
            default: begin
              nxt <= mem_rdata[IDX_W-1:0];
              st  <= S_SEND;
            end
          endcase
        end
        S_SEND: if (msg_ready) begin
          st   <= S_WAIT;
          wcnt <= '0;
        end
        default: if (tick) wcnt <= wcnt + DONE_ONE;
      endcase
      if (step) begin
        if (nxt == TERM) st <= S_IDLE;
        else begin
          st   <= S_FETCH;
          idx  <= nxt;
          bsel <= '0;
        end
      end
    end
  end

  assign mem_raddr = {idx, bsel};
  assign msg_valid = (st == S_SEND);
  assign msg_data  = msg;
  assign busy      = (st != S_IDLE);

  p_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT |-> wcnt < dly);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data));

  p_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(nxt) == TERM);

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && |pend) |=> busy);

  p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pend[3]) |=> idx == $past(start_warm));
endmodule

// File: tb/pbus_script_seq_tb_top.sv
module pbus_script_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ev_sleep = 0, ev_wake12 = 0, ev_wake3 = 0, ev_warm = 0, tick = 0;
  logic msg_ready = 1;
  logic [5:0] start_sleep = 6'd2, start_wake12 = 6'd10, start_wake3 = 6'd20, start_warm = 6'd30;
  logic [7:0] mem_raddr, mem_rdata;
  logic msg_valid, busy;
  logic [15:0] msg_data;
  logic [7:0] mem [0:255];
  logic [15:0] log_m [0:31];
  int log_t [0:31];
  int log_n = 0, cyc = 0, checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_raddr];

  pbus_script_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ev_sleep(ev_sleep), .ev_wake12(ev_wake12),
    .ev_wake3(ev_wake3), .ev_warm(ev_warm), .start_sleep(start_sleep),
    .start_wake12(start_wake12), .start_wake3(start_wake3), .start_warm(start_warm),
    .tick(tick), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_data(msg_data), .busy(busy));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && msg_valid && msg_ready && log_n < 32) begin
      log_m[log_n] <= msg_data;
      log_t[log_n] <= cyc;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [15:0] m, input logic [7:0] d, input logic [7:0] n);
    mem[4*i] = m[15:8]; mem[4*i+1] = m[7:0]; mem[4*i+2] = d; mem[4*i+3] = n;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic wait_msgs(input int n);
    for (int k = 0; k < 50 && log_n < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check(msg_valid == 0, "R1 valid", msg_valid, 0);
    cycles(10);
    check(log_n == 0, "R1 no message", log_n, 0);
  endtask

  task automatic t_sleep_delay();
    ev_sleep = 1; @(negedge clk); ev_sleep = 0;
    check(busy == 0, "R10 busy one edge", busy, 0);
    @(negedge clk);
    check(busy == 1, "R10 busy rise", busy, 1);
    wait_msgs(1);
    check(log_m[0] == 16'h20F0, "R2 R7 first message", log_m[0], 16'h20F0);
    cycles(20);
    check(log_n == 1 && busy, "R4 no ticks", log_n, 1);
    pulse_tick(); cycles(3); pulse_tick(); cycles(15);
    check(log_n == 1, "R4 two ticks", log_n, 1);
    pulse_tick();
    wait_msgs(2);
    check(log_n == 2, "R4 third tick", log_n, 2);
    check(log_m[1] == 16'h1E78, "R3 next record", log_m[1], 16'h1E78);
    @(negedge clk);
    check(busy == 0, "R3 R10 end", busy, 0);
  endtask

  task automatic t_zero_delay();
    int b = log_n;
    ev_warm = 1; @(negedge clk); ev_warm = 0;
    wait_msgs(b + 2);
    check(log_m[b] == 16'h20FF, "R7 warm start", log_m[b], 16'h20FF);
    check(log_m[b+1] == 16'h207F, "R3 warm second", log_m[b+1], 16'h207F);
    check(log_t[b+1] - log_t[b] == 5, "R5 zero delay gap", log_t[b+1] - log_t[b], 5);
    cycles(2);
    check(busy == 0, "R3 warm end", busy, 0);
  endtask

  task automatic t_backpressure();
    int b = log_n;
    msg_ready = 0;
    ev_wake12 = 1; @(negedge clk); ev_wake12 = 0;
    cycles(10);
    check(msg_valid == 1 && msg_data == 16'h20FE, "R6 offered", msg_data, 16'h20FE);
    cycles(5);
    check(msg_valid == 1 && msg_data == 16'h20FE, "R6 held", msg_data, 16'h20FE);
    check(log_n == b, "R6 no handshake", log_n, b);
    msg_ready = 1;
    cycles(3);
    check(log_n == b + 1 && log_m[b] == 16'h20FE, "R6 R7 accepted", log_m[b], 16'h20FE);
    check(busy == 0, "R3 wake12 end", busy, 0);
  endtask

  task automatic t_pending_prio();
    int b = log_n;
    ev_sleep = 1; @(negedge clk); ev_sleep = 0;
    wait_msgs(b + 1);
    ev_wake3 = 1; @(negedge clk); ev_wake3 = 0;
    ev_wake12 = 1; @(negedge clk); ev_wake12 = 0;
    ev_warm = 1; @(negedge clk); ev_warm = 0;
    cycles(10);
    check(log_n == b + 1, "R8 running undisturbed", log_n, b + 1);
    pulse_tick(); pulse_tick(); pulse_tick();
    wait_msgs(b + 5);
    check(log_m[b+1] == 16'h1E78, "R8 running completes", log_m[b+1], 16'h1E78);
    check(log_m[b+2] == 16'h20FF, "R9 warm first", log_m[b+2], 16'h20FF);
    check(log_m[b+3] == 16'h207F, "R9 warm chain", log_m[b+3], 16'h207F);
    check(log_m[b+4] == 16'h20FE, "R9 wake12 next", log_m[b+4], 16'h20FE);
    wait_msgs(b + 6);
    check(log_n == b + 6 && log_m[b+5] == 16'h810E, "R9 wake3 last", log_m[b+5], 16'h810E);
    cycles(2);
    check(busy == 1, "R4 wake3 waiting", busy, 1);
    pulse_tick(); @(negedge clk);
    check(busy == 0, "R10 final idle", busy, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    put(2, 16'h20F0, 8'd3, 8'd5);
    put(5, 16'h1E78, 8'd0, 8'h3F);
    put(10, 16'h20FE, 8'd0, 8'h3F);
    put(20, 16'h810E, 8'd1, 8'h3F);
    put(30, 16'h20FF, 8'd0, 8'd31);
    put(31, 16'h207F, 8'd0, 8'h3F);
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sleep_delay();
    t_zero_delay();
    t_backpressure();
    t_pending_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected 0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule